// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Access Sequencer

This block sits between a simple single-beat bus and a byte-wide SPI shift engine and serves one flash chip-select. Every bus access of one to four bytes becomes a complete flash transaction. A control word chooses how the access is carried out. The choices are plain read, fast read, programmed write, and a raw pass-through mode in which software drives the flash one byte at a time.

In the three command modes the sequencer frames the chip select on its own. It sends the opcode, a three- or four-byte address and any dummy bytes the control word asks for, then moves the data. In pass-through mode it only moves the data bytes, and software decides when chip select is low by setting or clearing a stop bit in the control word. The shift engine is reached through a request/acknowledge byte exchange.

A small configuration port loads the control word and a dummy-fill byte. The control word reads back on its own output, including the stop bit that the sequencer updates.

Top module: `flash_access_seq`

## Requirements
- R1: The access mode is control bits [1:0] (0 plain read, 1 fast read, 2 write, 3 pass-through); in plain-read mode the opcode byte sent is always 0x03, whatever control bits [23:16] hold.
- R2: In fast-read and write modes the opcode byte sent is control bits [23:16].
- R3: After the opcode the address goes out most significant byte first; bits [31:24] are sent only when `wide_addr_en` is high, otherwise bits [23:0] in three bytes.
- R4: Fast-read mode sends ({ctrl[14], ctrl[7:6]} × 8) dummy bytes after the address, halved when ctrl[28] is set; each carries the low byte last written with `cfg_sel`=1; no other mode sends dummy bytes.
- R5: `bus_size` holds byte count minus one; data bytes move least significant first; write data goes out from `bus_wdata[7:0]` upward, a read shifts out 0x00 per byte and the first byte received lands in `bus_rdata[7:0]`.
- R6: `spi_cs_n` equals control bit 2; a command-mode access clears it before the opcode and sets it again as the access completes, so it is low for every byte of that access; `cfg_sel`=0 writes the whole control word.
- R7: A write while `write_allow` is low completes without any SPI byte and without touching chip select.
- R8: In pass-through mode only the data bytes are exchanged and chip select stays as software left it.
- R9: A read in write mode or a write in plain or fast-read mode completes with zero read data and no SPI byte.
- R10: Reset, at any time, leaves chip select high, no SPI request, `bus_done` low and the control word at 0x00000004.
- R11: `spi_req` stays high with stable `spi_tx` until `spi_ack`; `bus_done` is a one-cycle pulse ending each access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | One-cycle access request |
| bus_we | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 32 | Flash byte address |
| bus_wdata | input | 32 | Write data, first byte in [7:0] |
| bus_size | input | 2 | Byte count minus one |
| bus_done | output | 1 | Access complete pulse |
| bus_rdata | output | 32 | Assembled read data, valid with bus_done |
| wide_addr_en | input | 1 | Send four address bytes |
| write_allow | input | 1 | Writes permitted for this chip-select |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = control word, 1 = dummy-fill byte |
| cfg_wdata | input | 32 | Configuration write data |
| ctrl_rd | output | 32 | Current control word |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_req | output | 1 | Byte exchange request |
| spi_tx | output | 8 | Byte to shift out |
| spi_ack | input | 1 | Byte exchange complete |
| spi_rx | input | 8 | Byte shifted in |

## Verification
The assertions take it that the shift engine acknowledges only while a request is pending, and that a new access request or a configuration write never arrives while an access is still in flight. The bench's byte-exchange model acknowledges a request once, on the half cycle after it sees it, and drops the acknowledge before the next request can appear. Every access and configuration write is issued only after the previous `bus_done` pulse has been seen. The one reset in mid-access leaves both the bus and configuration inputs idle.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  localparam int CTRL_W     = 32;
  localparam int MODE_LSB   = 0;
  localparam int STOP_BIT   = 2;
  localparam int DUMLO_LSB  = 6;
  localparam int DUMHI_BIT  = 14;
  localparam int OPC_LSB    = 16;
  localparam int DUAL_BIT   = 28;
  localparam int DUM_W      = 6;
  localparam logic [7:0] READ_OPCODE = 8'h03;

  typedef enum logic [1:0] {
    M_READ  = 2'd0,
    M_FAST  = 2'd1,
    M_WRITE = 2'd2,
    M_USER  = 2'd3
  } fmode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_ADDR, S_DUMMY, S_DATA, S_DONE
  } fstate_e;

  typedef struct packed {
    fmode_e             mode;
    logic [7:0]         opcode;
    logic               wide_addr;
    logic [DUM_W-1:0]   n_dummy;
    logic               framed;
    logic               reject;
  } plan_t;

endpackage

// File: rtl/fseq_regs.sv
module fseq_regs
  import fseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              frame_open,
  input  logic              frame_close,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [7:0]        dummy_q
);

  localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(1) << STOP_BIT;

  logic unused_upper;
  assign unused_upper = ^wr_data[CTRL_W-1:8] & wr_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= CTRL_RST;
      dummy_q <= 8'h00;
    end else begin
      if (wr_en && !wr_sel) ctrl_q  <= wr_data;
      if (wr_en &&  wr_sel) dummy_q <= wr_data[7:0];
      if (frame_open)       ctrl_q[STOP_BIT] <= 1'b0;
      if (frame_close)      ctrl_q[STOP_BIT] <= 1'b1;
    end
  end

  // the stop bit follows the sequencer's framing strobes
  assert_open_clears_R6: assert property (@(posedge clk) disable iff (rst)
    frame_open |=> !ctrl_q[STOP_BIT]);
  assert_close_sets_R6: assert property (@(posedge clk) disable iff (rst)
    frame_close |=> ctrl_q[STOP_BIT]);

endmodule

// File: rtl/fseq_plan.sv
module fseq_plan
  import fseq_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              wide_en,
  input  logic              we,
  input  logic              wr_allow,
  output plan_t             plan
);

  fmode_e            mode;
  logic [2:0]        dum_units;
  logic [DUM_W-1:0]  dum_full;

  logic unused_fields;
  assign unused_fields = ^{ctrl[31:29], ctrl[27:24], ctrl[15], ctrl[13:8], ctrl[5:2]};

  always_comb begin
    mode      = fmode_e'(ctrl[MODE_LSB +: 2]);
    dum_units = {ctrl[DUMHI_BIT], ctrl[DUMLO_LSB +: 2]};
    dum_full  = {dum_units, 3'b000};

    plan.mode      = mode;
    plan.wide_addr = wide_en;
    plan.opcode    = (mode == M_READ) ? READ_OPCODE : ctrl[OPC_LSB +: 8];
    if (mode == M_FAST)
      plan.n_dummy = ctrl[DUAL_BIT] ? (dum_full >> 1) : dum_full;
    else
      plan.n_dummy = '0;
    plan.framed = (mode != M_USER);
    if (we)
      plan.reject = !wr_allow || (mode == M_READ) || (mode == M_FAST);
    else
      plan.reject = (mode == M_WRITE);
  end

endmodule

// File: rtl/fseq_engine.sv
module fseq_engine
  import fseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int SZ_W  = $clog2(NB),
  localparam int AB    = ADDR_W / 8,
  localparam int LW    = $clog2(AB),
  localparam int CNT_W = DUM_W
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SZ_W-1:0]   size,
  input  plan_t             plan,
  input  logic [7:0]        dummy_byte,
  output logic              xfer_req,
  output logic [7:0]        xfer_tx,
  input  logic              xfer_ack,
  input  logic [7:0]        xfer_rx,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              frame_open,
  output logic              frame_close
);

  fstate_e           state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [SZ_W-1:0]   size_q;
  logic              we_q;
  plan_t             plan_q;
  logic              req_q;
  logic [7:0]        tx_q;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;

  logic [LW-1:0]     last_lane;
  logic [LW-1:0]     lane;
  logic              addr_last;
  logic [7:0]        cur_byte;

  // address byte order: most significant lane first
  always_comb begin
    last_lane = plan_q.wide_addr ? LW'(AB - 1) : LW'(AB - 2);
    lane      = last_lane - cnt_q[LW-1:0];
    addr_last = (cnt_q == CNT_W'(last_lane));
    unique case (state_q)
      S_CMD:   cur_byte = plan_q.opcode;
      S_ADDR:  cur_byte = addr_q[8*lane +: 8];
      S_DUMMY: cur_byte = dummy_byte;
      S_DATA:  cur_byte = we_q ? wdata_q[8*cnt_q[SZ_W-1:0] +: 8] : 8'h00;
      default: cur_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      size_q  <= '0;
      we_q    <= 1'b0;
      plan_q  <= '0;
      req_q   <= 1'b0;
      tx_q    <= 8'h00;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (req) begin
            addr_q  <= addr;
            wdata_q <= wdata;
            size_q  <= size;
            we_q    <= we;
            plan_q  <= plan;
            cnt_q   <= '0;
            rdata_q <= '0;
            if (plan.reject)      state_q <= S_DONE;
            else if (plan.framed) state_q <= S_CMD;
            else                  state_q <= S_DATA;
          end
        end
        S_DONE: begin
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: begin
          if (!req_q) begin
            req_q <= 1'b1;
            tx_q  <= cur_byte;
          end else if (xfer_ack) begin
            req_q <= 1'b0;
            cnt_q <= cnt_q + CNT_W'(1);
            unique case (state_q)
              S_CMD: begin
                cnt_q   <= '0;
                state_q <= S_ADDR;
              end
              S_ADDR: begin
                if (addr_last) begin
                  cnt_q   <= '0;
                  state_q <= (plan_q.n_dummy != '0) ? S_DUMMY : S_DATA;
                end
              end
              S_DUMMY: begin
                if (cnt_q == plan_q.n_dummy - CNT_W'(1)) begin
                  cnt_q   <= '0;
                  state_q <= S_DATA;
                end
              end
              S_DATA: begin
                if (!we_q) rdata_q[8*cnt_q[SZ_W-1:0] +: 8] <= xfer_rx;
                if (cnt_q[SZ_W-1:0] == size_q) state_q <= S_DONE;
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  assign frame_open  = (state_q == S_IDLE) && req && plan.framed && !plan.reject;
  assign frame_close = (state_q == S_DONE) && plan_q.framed && !plan_q.reject;
  assign xfer_req    = req_q;
  assign xfer_tx     = tx_q;
  assign done        = done_q;
  assign rdata       = rdata_q;

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx)));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE || state_q == S_DONE) |-> !xfer_req);
  assert_dummy_only_fast_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DUMMY) |-> (plan_q.mode == M_FAST && cnt_q < plan_q.n_dummy));

endmodule

// File: rtl/flash_access_seq.sv
module flash_access_seq
  import fseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int SZ_W  = $clog2(DATA_W / 8)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [SZ_W-1:0]   bus_size,
  output logic              bus_done,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              wide_addr_en,
  input  logic              write_allow,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output logic [CTRL_W-1:0] ctrl_rd,
  output logic              spi_cs_n,
  output logic              spi_req,
  output logic [7:0]        spi_tx,
  input  logic              spi_ack,
  input  logic [7:0]        spi_rx
);

  logic [CTRL_W-1:0] ctrl_q;
  logic [7:0]        dummy_q;
  plan_t             plan;
  logic              frame_open;
  logic              frame_close;

  fseq_regs u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (cfg_we),
    .wr_sel      (cfg_sel),
    .wr_data     (cfg_wdata),
    .frame_open  (frame_open),
    .frame_close (frame_close),
    .ctrl_q      (ctrl_q),
    .dummy_q     (dummy_q)
  );

  fseq_plan u_plan (
    .ctrl     (ctrl_q),
    .wide_en  (wide_addr_en),
    .we       (bus_we),
    .wr_allow (write_allow),
    .plan     (plan)
  );

  fseq_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
    .clk         (clk),
    .rst         (rst),
    .req         (bus_req),
    .we          (bus_we),
    .addr        (bus_addr),
    .wdata       (bus_wdata),
    .size        (bus_size),
    .plan        (plan),
    .dummy_byte  (dummy_q),
    .xfer_req    (spi_req),
    .xfer_tx     (spi_tx),
    .xfer_ack    (spi_ack),
    .xfer_rx     (spi_rx),
    .done        (bus_done),
    .rdata       (bus_rdata),
    .frame_open  (frame_open),
    .frame_close (frame_close)
  );

  assign ctrl_rd  = ctrl_q;
  assign spi_cs_n = ctrl_q[STOP_BIT];

  // command-mode bytes never leave while the chip is deselected
  assert_cs_framed_R6: assert property (@(posedge clk) disable iff (rst)
    (spi_req && ctrl_q[MODE_LSB +: 2] != M_USER) |-> !spi_cs_n);
  // completion of a framed access leaves the chip deselected
  assert_cs_released_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_done && ctrl_q[MODE_LSB +: 2] != M_USER) |-> spi_cs_n);

endmodule

// File: tb/sim_flash_access_seq.sv
module sim_flash_access_seq;

  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [1:0]  sz;
    logic        we;
    logic        wen;
    logic        a4;
    logic [7:0]  dum;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h00AB_0004, 32'h0012_3456, 32'h0000_0000, 2'd3, 1'b0, 1'b0, 1'b0, 8'h00},
    '{32'h0000_40C4, 32'h89AB_CDEF, 32'h0000_0000, 2'd1, 1'b0, 1'b0, 1'b1, 8'h33},
    '{32'h000B_0045, 32'h0000_0010, 32'h0000_0000, 2'd0, 1'b0, 1'b0, 1'b0, 8'h5A},
    '{32'h10BB_40C5, 32'h0102_0304, 32'h0000_0000, 2'd3, 1'b0, 1'b0, 1'b1, 8'hA5},
    '{32'h0002_0006, 32'h00AB_CDEF, 32'hDDCC_BBAA, 2'd2, 1'b1, 1'b1, 1'b0, 8'h00},
    '{32'h0002_0006, 32'h00AB_CDEF, 32'hDDCC_BBAA, 2'd2, 1'b1, 1'b0, 1'b0, 8'h00},
    '{32'h0000_0003, 32'h0000_0000, 32'h4433_2211, 2'd3, 1'b1, 1'b1, 1'b0, 8'h00},
    '{32'h0000_0003, 32'h0000_0000, 32'h0000_0000, 2'd1, 1'b0, 1'b0, 1'b0, 8'h00},
    '{32'h0002_0006, 32'h0000_1000, 32'h0000_0000, 2'd3, 1'b0, 1'b1, 1'b0, 8'h00},
    '{32'h000B_0045, 32'h0000_1000, 32'h1234_5678, 2'd3, 1'b1, 1'b1, 1'b0, 8'h00},
    '{32'h000B_0005, 32'h00FE_DCBA, 32'h0000_0000, 2'd0, 1'b0, 1'b0, 1'b0, 8'h77},
    '{32'h0000_0003, 32'h0000_0000, 32'h0000_00EE, 2'd0, 1'b1, 1'b0, 1'b0, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_req, bus_we, bus_done;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_size;
  logic        wide_addr_en, write_allow;
  logic        cfg_we, cfg_sel;
  logic [31:0] cfg_wdata, ctrl_rd;
  logic        spi_cs_n, spi_req, spi_ack;
  logic [7:0]  spi_tx, spi_rx;

  always #10 clk = ~clk;

  flash_access_seq u0 (
    .clk(clk), .rst(rst),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_size(bus_size),
    .bus_done(bus_done), .bus_rdata(bus_rdata),
    .wide_addr_en(wide_addr_en), .write_allow(write_allow),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ctrl_rd(ctrl_rd), .spi_cs_n(spi_cs_n),
    .spi_req(spi_req), .spi_tx(spi_tx), .spi_ack(spi_ack), .spi_rx(spi_rx)
  );

  // byte-exchange model: acknowledges each request once, logs what it saw
  logic [7:0] tx_log [0:255];
  logic       cs_log [0:255];
  int         n_log = 0;
  int         log_base = 0;

  initial begin
    spi_ack = 1'b0;
    spi_rx  = 8'h00;
  end

  always @(negedge clk) begin
    if (spi_req && !spi_ack) begin
      spi_ack        <= 1'b1;
      spi_rx         <= 8'h40 + 8'(n_log - log_base);
      tx_log[n_log % 256] <= spi_tx;
      cs_log[n_log % 256] <= spi_cs_n;
      n_log          <= n_log + 1;
    end else begin
      spi_ack <= 1'b0;
    end
  end

  int checks = 0;
  int fails  = 0;

  logic [7:0]  exp_tx [0:127];
  int          exp_n;
  logic [31:0] exp_rd;
  logic        exp_framed;
  logic        exp_rej;

  task automatic chk(input string req, input logic ok, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    exp_tx[exp_n] = b;
    exp_n++;
  endtask

  task automatic build_exp(input vec_t v);
    logic [1:0] m;
    m = v.ctrl[1:0];
    exp_rej    = v.we ? (!v.wen || m < 2'd2) : (m == 2'd2);
    exp_framed = (m != 2'd3) && !exp_rej;
    exp_n      = 0;
    exp_rd     = 32'h0;
    if (!exp_rej) begin
      if (m != 2'd3) begin
        push((m == 2'd0) ? 8'h03 : v.ctrl[23:16]);
        if (v.a4) push(v.addr[31:24]);
        push(v.addr[23:16]);
        push(v.addr[15:8]);
        push(v.addr[7:0]);
        if (m == 2'd1) begin
          int d;
          d = int'({v.ctrl[14], v.ctrl[7:6]}) * 8;
          if (v.ctrl[28]) d = d / 2;
          for (int k = 0; k < d; k++) push(v.dum);
        end
      end
      for (int j = 0; j <= int'(v.sz); j++) begin
        if (!v.we) exp_rd[8*j +: 8] = 8'h40 + 8'(exp_n);
        push(v.we ? v.wdata[8*j +: 8] : 8'h00);
      end
    end
  endtask

  function automatic string tag_of(input vec_t v);
    logic [1:0] m;
    m = v.ctrl[1:0];
    if (v.we && !v.wen) return "R7";
    if (v.we ? (m < 2'd2) : (m == 2'd2)) return "R9";
    if (m == 2'd3) return "R8";
    if (m == 2'd1) return "R4";
    if (m == 2'd2) return "R2";
    return v.a4 ? "R3" : "R1";
  endfunction

  task automatic start_access(input vec_t v);
    bus_we = v.we; bus_addr = v.addr; bus_wdata = v.wdata; bus_size = v.sz;
    wide_addr_en = v.a4; write_allow = v.wen;
    log_base = n_log;
    @(negedge clk);
    bus_req = 1'b1;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int w;
    logic ok;
    logic stop_exp;
    cfg_write(1'b0, v.ctrl);
    cfg_write(1'b1, {24'hFFFFFF, v.dum});
    build_exp(v);
    start_access(v);
    w = 0;
    while (!bus_done && w < 4000) begin
      @(negedge clk);
      w++;
    end
    chk("R11", w < 4000, $sformatf("vec%0d completion", idx), 32'(w), 32'h0);
    // byte stream
    ok = ((n_log - log_base) == exp_n);
    if (ok) for (int k = 0; k < exp_n; k++)
      if (tx_log[(log_base + k) % 256] !== exp_tx[k]) ok = 1'b0;
    chk(tag_of(v), ok, $sformatf("vec%0d spi byte stream (count)", idx),
        32'(n_log - log_base), 32'(exp_n));
    // assembled read data
    chk("R5", bus_rdata === exp_rd, $sformatf("vec%0d read data", idx), bus_rdata, exp_rd);
    // chip select during and after the access
    ok = 1'b1;
    for (int k = 0; k < n_log - log_base; k++)
      if (cs_log[(log_base + k) % 256] !== (exp_framed ? 1'b0 : v.ctrl[2])) ok = 1'b0;
    chk("R6", ok, $sformatf("vec%0d cs during bytes", idx), 32'(ok), 32'h1);
    stop_exp = exp_framed ? 1'b1 : v.ctrl[2];
    chk("R6", ctrl_rd[2] === stop_exp && spi_cs_n === stop_exp,
        $sformatf("vec%0d stop bit after", idx), {31'h0, ctrl_rd[2]}, {31'h0, stop_exp});
    @(negedge clk);
    chk("R11", bus_done === 1'b0, $sformatf("vec%0d done pulse width", idx),
        {31'h0, bus_done}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    bus_size = '0; wide_addr_en = 1'b0; write_allow = 1'b0;
    cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk("R10", spi_cs_n === 1'b1, "cs after reset", {31'h0, spi_cs_n}, 32'h1);
    chk("R10", spi_req === 1'b0, "spi_req after reset", {31'h0, spi_req}, 32'h0);
    chk("R10", bus_done === 1'b0, "done after reset", {31'h0, bus_done}, 32'h0);
    chk("R10", ctrl_rd === 32'h0000_0004, "control word after reset", ctrl_rd, 32'h4);

    // table walk
    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // control word write and readback
    cfg_write(1'b0, 32'h1234_5678);
    chk("R6", ctrl_rd === 32'h1234_5678, "control readback", ctrl_rd, 32'h1234_5678);
    chk("R6", spi_cs_n === 1'b0, "cs follows bit 2", {31'h0, spi_cs_n}, 32'h0);

    // reset in the middle of a long fast read
    cfg_write(1'b0, VECS[3].ctrl);
    start_access(VECS[3]);
    repeat (12) @(negedge clk);
    chk("R6", spi_cs_n === 1'b0, "cs low mid-access", {31'h0, spi_cs_n}, 32'h0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10", spi_cs_n === 1'b1, "cs after mid-access reset", {31'h0, spi_cs_n}, 32'h1);
    chk("R10", spi_req === 1'b0, "spi_req after mid-access reset", {31'h0, spi_req}, 32'h0);
    chk("R10", ctrl_rd === 32'h0000_0004, "control after mid-access reset", ctrl_rd, 32'h4);
    repeat (2) @(negedge clk);

    // access after the aborted one still runs cleanly
    run_vec(VECS[0], NV);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule